// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit packed integer execution unit. Each operation takes two 128-bit source words, an opcode, a lane-width select, a signed/unsigned select and a 5-bit shift field. It applies the operation to every lane of the word independently. Lanes can be 8, 16 or 32 bits wide, so one word holds sixteen, eight or four lanes. The lane operations are wraparound and saturating add and subtract, minimum, maximum, three shifts, four bitwise functions and a leading-zero count.

A byte-granular funnel shift treats the two sources as one 256-bit value, with source B on top, and returns a 128-bit window of it. The lane datapath is built from two identical 64-bit halves. No lane ever straddles the two halves, so each half computes its lanes without reference to the other.

Operations enter through a valid/ready pair. The result is registered, so it appears one cycle after the operation is accepted. It stays on the output until the consumer takes it.

Top module: `pack_alu`

## Requirements
- R1: `in_lw` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. No carry or borrow passes from one lane into the next at any width.
- R2: Opcode 0 adds lane by lane and opcode 2 subtracts B from A lane by lane. Both wrap modulo 2^width.
- R3: Opcode 1 is a saturating add and opcode 3 is a saturating subtract. With `in_sgn`=1 the result is clamped to the signed range of the lane. With `in_sgn`=0 it is clamped to the range 0 up to all-ones.
- R4: Opcode 4 returns the lane minimum and opcode 5 the lane maximum of A and B. The comparison is signed when `in_sgn`=1 and unsigned otherwise.
- R5: Opcode 6 shifts left logically, 7 shifts right logically and 8 shifts right arithmetically. Each shifts A by the low log2(width) bits of `in_sh`. The arithmetic shift fills with the lane's top bit.
- R6: Opcodes 9, 10, 11 and 12 give A AND B, A OR B, A XOR B and NOT(A OR B).
- R7: Opcode 13 returns, in each lane, the count of leading zero bits of A. An all-zero lane returns the lane width.
- R8: Opcode 14 returns bits [8k+127:8k] of {B,A}, where k is `in_sh` clamped to at most 16. So k=0 returns A, and k of 16 or more returns B.
- R9: `in_ready` is high when no result is held or the held result is being taken. An operation is captured when `in_valid` and `in_ready` are both high, and its result shows with `out_valid` on the next cycle. While `out_ready` is low, `out_valid` and `out_res` hold. Results leave in the order the operations were accepted.
- R10: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0, `out_res` is 0 and `in_ready` is 1.
- R11: Opcode 15 returns an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_lw | input | 2 | Lane width select |
| in_sgn | input | 1 | Signed select for min/max and saturation |
| in_sh | input | 5 | Shift amount or funnel byte offset |
| in_a | input | 128 | Source A |
| in_b | input | 128 | Source B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 128 | Registered result |

## Verification
The bench feeds all-ones bytes plus one, at every lane width. A design that leaked carries across lanes would turn zero lanes into ones there. The saturation cases sit exactly on the signed and unsigned limits, where a wrong clamp shows up as a wrapped value or the wrong extreme.

Shift amounts larger than the lane are sent to catch a design that fails to mask the amount. Negative lanes under the arithmetic shift catch a zero fill. All-zero lanes under the count catch a count that stops one short of the width.

The funnel offsets 0, 1, 15, 16 and 20 catch off-by-one windows and a missing clamp. Random backpressure on `out_ready` exposes results that change, get dropped or get duplicated while stalled.

// File: rtl/pack_alu_pkg.sv
package pack_alu_pkg;

    localparam int DATA_W  = 128;
    localparam int HALF_W  = 64;
    localparam int SH_W    = 5;
    localparam int FSH_MAX = 16;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDS = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBS = 4'd3,
        OP_MIN  = 4'd4,
        OP_MAX  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_AND  = 4'd9,
        OP_OR   = 4'd10,
        OP_XOR  = 4'd11,
        OP_NOR  = 4'd12,
        OP_CLZ  = 4'd13,
        OP_FSH  = 4'd14,
        OP_NONE = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        LW_B8  = 2'd0,
        LW_B16 = 2'd1,
        LW_B32 = 2'd2,
        LW_RSV = 2'd3
    } lw_e;

    typedef struct packed {
        op_e             op;
        lw_e             lw;
        logic            sgn;
        logic [SH_W-1:0] sh;
    } ctl_t;

    // Funnel byte offsets beyond the top are pinned at the top.
    function automatic logic [SH_W-1:0] fsh_clamp(input logic [SH_W-1:0] s);
        return (s > SH_W'(FSH_MAX)) ? SH_W'(FSH_MAX) : s;
    endfunction

endpackage

// File: rtl/pack_alu_lane.sv
module pack_alu_lane
    import pack_alu_pkg::*;
#(
    parameter int LW = 8,
    localparam int SW = $clog2(LW)
) (
    input  op_e           op,
    input  logic          sgn,
    input  logic [SW-1:0] amt,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] y
);

    logic [LW:0]   sum, dif;
    logic [LW-1:0] smax, smin, clz;
    logic          ovf_add, ovf_sub, lt;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        dif  = {1'b0, a} - {1'b0, b};
        smax = {1'b0, {(LW-1){1'b1}}};
        smin = {1'b1, {(LW-1){1'b0}}};
        ovf_add = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
        ovf_sub = (a[LW-1] != b[LW-1]) && (dif[LW-1] != a[LW-1]);
        lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
        clz = LW'(LW);
        for (int i = 0; i < LW; i++) begin
            if (a[i]) clz = LW'(LW - 1 - i);
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = sum[LW-1:0];
            OP_SUB:  y = dif[LW-1:0];
            OP_ADDS: begin
                if (sgn) y = ovf_add ? (a[LW-1] ? smin : smax) : sum[LW-1:0];
                else     y = sum[LW] ? {LW{1'b1}} : sum[LW-1:0];
            end
            OP_SUBS: begin
                if (sgn) y = ovf_sub ? (a[LW-1] ? smin : smax) : dif[LW-1:0];
                else     y = dif[LW] ? {LW{1'b0}} : dif[LW-1:0];
            end
            OP_MIN:  y = lt ? a : b;
            OP_MAX:  y = lt ? b : a;
            OP_SLL:  y = a << amt;
            OP_SRL:  y = a >> amt;
            OP_SRA:  y = LW'($signed(a) >>> amt);
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_CLZ:  y = clz;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pack_alu_half.sv
module pack_alu_half
    import pack_alu_pkg::*;
#(
    parameter int HW = HALF_W,
    localparam int NW = 3
) (
    input  ctl_t          ctl,
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    output logic [HW-1:0] y
);

    logic [HW-1:0] res_w [NW];

    for (genvar w = 0; w < NW; w++) begin : g_width
        localparam int LW = 8 << w;
        localparam int SW = $clog2(LW);
        logic [HW-1:0] r;
        for (genvar i = 0; i < HW / LW; i++) begin : g_lane
            pack_alu_lane #(.LW(LW)) u_lane (
                .op  (ctl.op),
                .sgn (ctl.sgn),
                .amt (ctl.sh[SW-1:0]),
                .a   (a[i*LW +: LW]),
                .b   (b[i*LW +: LW]),
                .y   (r[i*LW +: LW])
            );
        end
        assign res_w[w] = r;
    end

    always_comb begin
        unique case (ctl.lw)
            LW_B8:   y = res_w[0];
            LW_B16:  y = res_w[1];
            default: y = res_w[2];
        endcase
    end

endmodule

// File: rtl/pack_alu_funnel.sv
module pack_alu_funnel
    import pack_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [SH_W-1:0] sh,
    input  logic [DW-1:0]   lo,
    input  logic [DW-1:0]   hi,
    output logic [DW-1:0]   y
);

    logic [SH_W-1:0] off;
    logic [2*DW-1:0] cat;

    always_comb begin
        off = fsh_clamp(sh);
        cat = {hi, lo} >> {off, 3'b000};
        y   = cat[DW-1:0];
    end

endmodule

// File: rtl/pack_alu.sv
module pack_alu
    import pack_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int HW = HALF_W,
    localparam int NH = DW / HW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [3:0]      in_op,
    input  logic [1:0]      in_lw,
    input  logic            in_sgn,
    input  logic [SH_W-1:0] in_sh,
    input  logic [DW-1:0]   in_a,
    input  logic [DW-1:0]   in_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [DW-1:0]   out_res
);

    ctl_t          ctl;
    logic [DW-1:0] lane_res, fsh_res, nxt;

    assign ctl = '{op: op_e'(in_op), lw: lw_e'(in_lw), sgn: in_sgn, sh: in_sh};

    for (genvar h = 0; h < NH; h++) begin : g_half
        pack_alu_half #(.HW(HW)) u_half (
            .ctl (ctl),
            .a   (in_a[h*HW +: HW]),
            .b   (in_b[h*HW +: HW]),
            .y   (lane_res[h*HW +: HW])
        );
    end

    pack_alu_funnel #(.DW(DW)) u_fsh (
        .sh (in_sh),
        .lo (in_a),
        .hi (in_b),
        .y  (fsh_res)
    );

    assign nxt      = (ctl.op == OP_FSH) ? fsh_res : lane_res;
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_res   <= nxt;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pack_alu_chk.sv
module pack_alu_chk #(
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [3:0]    in_op,
    input logic [4:0]    in_sh,
    input logic [DW-1:0] in_a,
    input logic [DW-1:0] in_b,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_res
);

    p_reset_r10: assert property (@(posedge clk) rst |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_res));

    p_take_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);

    p_and_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 4'd9 |=> out_res == $past(in_a & in_b));

    p_fsh0_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 4'd14 && in_sh == 5'd0 |=> out_res == $past(in_a));

    p_zero_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 4'd15 |=> out_res == '0);

endmodule

bind pack_alu pack_alu_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_sh     (in_sh),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res)
);

// File: tb/pack_alu_tb_top.sv
`timescale 1ns/1ps
module pack_alu_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [3:0]   in_op;
    logic [1:0]   in_lw;
    logic         in_sgn;
    logic [4:0]   in_sh;
    logic [127:0] in_a, in_b;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_res;

    int n_chk = 0;
    int n_err = 0;
    bit ready_rand = 0;
    bit hold_pend = 0;
    logic [127:0] held;
    logic [127:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    pack_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_lw(in_lw), .in_sgn(in_sgn), .in_sh(in_sh),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_res(out_res)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic logic [127:0] model(input int op, input int lw, input bit sgn,
                                           input int sh, input logic [127:0] a,
                                           input logic [127:0] b);
        logic [127:0] r = '0;
        logic [255:0] c;
        longint x, y, sx, sy, m, v, hi, lo, ka, kb;
        int w, k, off;
        if (op == 14) begin
            off = (sh > 16) ? 16 : sh;
            c = {b, a};
            c = c >> (off * 8);
            return c[127:0];
        end
        if (op == 15) return '0;
        w  = (lw == 0) ? 8 : (lw == 1) ? 16 : 32;
        m  = (64'sd1 <<< w) - 1;
        hi = sgn ? (m >>> 1) : m;
        lo = sgn ? -(m >>> 1) - 1 : 0;
        k  = sh % w;
        for (int l = 0; l < 128 / w; l++) begin
            x  = longint'(a >> (l * w)) & m;
            y  = longint'(b >> (l * w)) & m;
            sx = ((x >>> (w - 1)) & 1) != 0 ? x - (m + 1) : x;
            sy = ((y >>> (w - 1)) & 1) != 0 ? y - (m + 1) : y;
            ka = sgn ? sx : x;
            kb = sgn ? sy : y;
            case (op)
                0: v = x + y;
                2: v = x - y;
                1, 3: begin
                    v = (op == 1) ? ka + kb : ka - kb;
                    if (v > hi) v = hi;
                    if (v < lo) v = lo;
                end
                4: v = (ka < kb) ? x : y;
                5: v = (ka < kb) ? y : x;
                6: v = x << k;
                7: v = x >> k;
                8: v = sx >>> k;
                9: v = x & y;
                10: v = x | y;
                11: v = x ^ y;
                12: v = ~(x | y);
                default: begin
                    v = w;
                    for (int i = w - 1; i >= 0; i--) begin
                        if (((x >>> i) & 1) != 0) begin
                            v = w - 1 - i;
                            break;
                        end
                    end
                end
            endcase
            r = r | (128'(v & m) << (l * w));
        end
        return r;
    endfunction

    task automatic send(input string req, input int op, input int lw, input bit sgn,
                        input int sh, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_op = op[3:0]; in_lw = lw[1:0]; in_sgn = sgn; in_sh = sh[4:0];
        in_a = a; in_b = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(op, lw, sgn, sh, a, b));
        tag_q.push_back(req);
        @(posedge clk);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Monitor and scoreboard
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            out_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (!rst) begin
                if (hold_pend)
                    check(out_valid && out_res == held, "R9 hold", out_res, held);
                hold_pend = 0;
                if (out_valid && !out_ready) begin
                    hold_pend = 1;
                    held = out_res;
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R9 unexpected result", out_res, '0);
                    end else begin
                        logic [127:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_res == e, t, out_res, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R9 watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_lw = '0; in_sgn = 1'b0;
        in_sh = '0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(!out_valid && out_res == '0 && in_ready, "R10 in reset", out_res, '0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(!out_valid && out_res == '0 && in_ready, "R10 after reset", out_res, '0);

        // R1: lane isolation at every width (all-ones + 1 wraps to zero per lane)
        for (int lw = 0; lw < 4; lw++)
            send("R1 lane isolation", 0, lw, 0, 0, '1,
                 (lw == 0) ? {16{8'h01}} : (lw == 1) ? {8{16'h0001}} : {4{32'h1}});
        // R2: wrap add and subtract
        send("R2 sub wrap", 2, 2, 0, 0, '0, {4{32'h1}});
        send("R2 add mixed", 0, 1, 0, 0, {8{16'h8001}}, {8{16'h7fff}});
        // R3: saturation limits
        send("R3 uadd sat", 1, 0, 0, 0, {16{8'hf0}}, {16{8'h20}});
        send("R3 sadd pos sat", 1, 0, 1, 0, {16{8'h70}}, {16{8'h20}});
        send("R3 sadd neg sat", 1, 1, 1, 0, {8{16'h8000}}, {8{16'hffff}});
        send("R3 usub sat", 3, 2, 0, 0, {4{32'h10}}, {4{32'h20}});
        send("R3 ssub sat", 3, 0, 1, 0, {16{8'h80}}, {16{8'h01}});
        // R4: signed vs unsigned compare
        send("R4 min signed", 4, 0, 1, 0, {16{8'h80}}, {16{8'h01}});
        send("R4 min unsigned", 4, 0, 0, 0, {16{8'h80}}, {16{8'h01}});
        send("R4 max signed", 5, 2, 1, 0, {4{32'h80000000}}, {4{32'h1}});
        // R5: shift masking and sign fill
        send("R5 sll masked", 6, 0, 0, 9, {16{8'h81}}, '0);
        send("R5 srl", 7, 1, 0, 20, {8{16'h8000}}, '0);
        send("R5 sra sign fill", 8, 2, 0, 31, {4{32'h80000000}}, '0);
        send("R5 sra 8", 8, 0, 0, 3, {16{8'h90}}, '0);
        // R6: bitwise
        for (int op = 9; op <= 12; op++)
            send("R6 bitwise", op, 0, 0, 0, {4{32'hf0f0_a5a5}}, {4{32'h0ff0_5a0f}});
        // R7: leading zeros including all-zero lanes
        send("R7 clz 8", 13, 0, 0, 0, {8'h00, 8'h01, 8'h80, 8'h10, {12{8'h00}}}, '0);
        send("R7 clz 16", 13, 1, 0, 0, {16'h0000, 16'h0001, {6{16'h00ff}}}, '0);
        send("R7 clz 32", 13, 2, 0, 0, {32'h0, 32'h1, 32'h00008000, 32'hffffffff}, '0);
        // R8: funnel offsets
        send("R8 funnel 0", 14, 0, 0, 0, rnd128(), rnd128());
        send("R8 funnel 1", 14, 0, 0, 1, rnd128(), rnd128());
        send("R8 funnel 15", 14, 0, 0, 15, rnd128(), rnd128());
        send("R8 funnel 16", 14, 0, 0, 16, rnd128(), rnd128());
        send("R8 funnel clamp", 14, 0, 0, 20, rnd128(), rnd128());
        // R11: reserved opcode
        send("R11 zero op", 15, 0, 0, 0, '1, '1);
        // R9: random traffic under backpressure
        ready_rand = 1;
        for (int n = 0; n < 300; n++)
            send("R9 random", $urandom % 16, $urandom % 4, 1'($urandom % 2),
                 $urandom % 32, rnd128(), rnd128());
        @(negedge clk);
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
        check(!out_valid && exp_q.size() == 0, "R9 drained", 128'(out_valid), '0);
        finish_run();
    end

endmodule